// File: doc/BRIEF.md
# Software Interrupt Gate Protection Checker

This unit decides whether a software interrupt may enter its handler. A request gives the vector, the operating mode, the current privilege level, the I/O privilege level, the mode-extension enable and the vector's redirection-bitmap bit. It also gives the bases and limits of the interrupt and descriptor tables. The unit reads the gate entry through a request/response memory port, and when the gate names a code segment it reads that segment's descriptor as well. It then reports success with the handler selector and offset, or the first fault it finds, with its class and a 16-bit error code.

The checks run in a fixed order, and the first one that fails ends the request:
1. virtual-8086 privilege rule
2. interrupt table limit
3. gate type
4. gate privilege
5. gate presence
6. target selector
7. target type
8. target privilege
9. target presence

Real mode skips every descriptor rule and takes the handler address from a 4-byte table entry. The unit does not push the stack or switch tasks; a task gate only has its selector returned.

Top module: `swint_gate_check`

## Requirements
- R1: In virtual-8086 mode (mode=1) with IOPL below 3, a general-protection fault (class 1, error 0) is reported when the extension enable is 0. When the enable is 1, the fault is reported only if the redirection bit is 1. In every other case the request proceeds under the legacy protected rules.
- R2: Outside real mode, a general-protection fault is reported if the last byte of the gate entry lies past the interrupt table limit. The entry is 8 bytes in protected and virtual-8086 modes and 16 bytes in long mode (mode=3). The error code is vector·8+2, which sets the table flag at bit 1.
- R3: The gate type is taken from bits 43:40 of the gate, and bit 44 must be 0. Protected and virtual-8086 modes accept types 5, 6, 7, 14 and 15. Long mode accepts only 14 and 15. Any other type is a general-protection fault with error vector·8+2.
- R4: If the gate DPL (bits 46:45) is below the CPL, a general-protection fault with error vector·8+2 is reported.
- R5: If the gate's present bit (bit 47) is 0, a not-present fault (class 2) with error vector·8+2 is reported.
- R6: The target selector is gate bits 31:16. Each of the following is a general-protection fault whose error is the selector with bits 1:0 cleared:
  - a null selector (bits 15:2 all zero);
  - table-indicator bit 2 set while the local table is flagged null;
  - index·8+7 past the limit of the selected table.
- R7: The target descriptor must be a code segment (bits 44 and 43 both 1). In long mode its bit 53 must also be 1. Otherwise a general-protection fault with the selector error is reported.
- R8: If the target DPL (bits 46:45) exceeds the CPL, a general-protection fault with the selector error is reported.
- R9: If the target's present bit (bit 47) is 0, a not-present fault with the selector error is reported.
- R10: When several rules fail, only the earliest in the fixed order is reported.
- R11: Outside long mode, a valid present gate of type 5 succeeds with the gate selector and offset, and no target descriptor is read.
- R12: In real mode (mode=0), the word at idt_base+vector·4 is read with no limit or descriptor check. The handler selector is read data bits 31:16 and the offset is bits 15:0.
- R13: mem_req stays high with mem_addr stable until mem_rvalid. done is a one-cycle pulse, and the results hold until the next start.
- R14: On success, ok is 1, the class and error are 0, and the handler selector and offset come from gate bits 31:16 and {63:48, 15:0}.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset |
| start | input | 1 | Begin a check (taken only when idle) |
| vector | input | 8 | Interrupt vector |
| mode | input | 2 | 0 real, 1 virtual-8086, 2 protected, 3 long |
| cpl | input | 2 | Current privilege level |
| iopl | input | 2 | I/O privilege level |
| vme_en | input | 1 | Virtual-mode extensions enabled |
| redir_bit | input | 1 | Redirection-bitmap bit of this vector |
| idt_base | input | ADDR_W | Interrupt table base |
| idt_limit | input | LIMIT_W | Interrupt table limit |
| gdt_base | input | ADDR_W | Global table base |
| gdt_limit | input | LIMIT_W | Global table limit |
| ldt_base | input | ADDR_W | Local table base |
| ldt_limit | input | LIMIT_W | Local table limit |
| ldt_null | input | 1 | Local table selector is null |
| mem_req | output | 1 | Read request, held until response |
| mem_addr | output | ADDR_W | Byte address of the read |
| mem_rvalid | input | 1 | Read data valid |
| mem_rdata | input | 64 | Read data, byte at mem_addr in bits 7:0 |
| done | output | 1 | Result valid pulse |
| ok | output | 1 | Request passed every check |
| fault_cls | output | 2 | 0 none, 1 general protection, 2 not present |
| err_code | output | 16 | {index, TI, table flag, external} |
| hnd_sel | output | 16 | Handler selector |
| hnd_off | output | 32 | Handler offset (low 32 bits) |

## Verification
With the bench memory answering one cycle after each request, done follows the start cycle after a fixed number of edges. It comes after one edge for an R1 or R2 fault. It comes after three edges when the gate read decides the result, which covers gate faults, selector faults, task gates and real mode. It comes after five edges when the target descriptor is also read. The bench counts edges from start to done for every vector and compares that count with the figure set by which rule should decide. All outputs are sampled on the falling edge, and the results are checked again a few cycles later to confirm they hold.

// File: rtl/swg_pkg.sv
package swg_pkg;
    typedef enum logic [1:0] {MD_REAL = 2'd0, MD_V86 = 2'd1, MD_PROT = 2'd2, MD_LONG = 2'd3} mode_e;
    typedef enum logic [1:0] {FC_NONE = 2'd0, FC_GP = 2'd1, FC_NP = 2'd2} fclass_e;
    typedef enum logic [1:0] {ST_IDLE, ST_GATE, ST_TGT, ST_DONE} state_e;

    typedef struct packed {
        fclass_e     cls;
        logic [15:0] err;
    } fault_t;

    localparam fault_t NO_FAULT = '{cls: FC_NONE, err: 16'h0000};

    // error code pointing at an interrupt table entry
    function automatic logic [15:0] idt_err(input logic [7:0] vec);
        return {5'b0, vec, 3'b010};
    endfunction

    // error code from selector bits 15:2 (requested privilege dropped)
    function automatic logic [15:0] sel_err(input logic [13:0] sel_hi);
        return {sel_hi, 2'b00};
    endfunction
endpackage

// File: rtl/swg_entry_check.sv
module swg_entry_check
    import swg_pkg::*;
#(
    parameter int LIMIT_W = 16
) (
    input  logic [1:0]         mode,
    input  logic [1:0]         iopl,
    input  logic               vme_en,
    input  logic               redir_bit,
    input  logic [7:0]         vector,
    input  logic [LIMIT_W-1:0] idt_limit,
    output fault_t             flt
);
    localparam int CW = (LIMIT_W > 12) ? LIMIT_W : 12;

    logic [11:0]   span;
    logic [CW-1:0] span_c;
    logic [CW-1:0] lim_c;

    always_comb begin
        span   = (mode == MD_LONG) ? {vector, 4'hF} : {1'b0, vector, 3'h7};
        span_c = CW'(span);
        lim_c  = CW'(idt_limit);
        flt    = NO_FAULT;
        if (mode == MD_V86 && iopl != 2'd3 && (!vme_en || redir_bit)) begin
            flt = '{cls: FC_GP, err: 16'h0000};
        end else if (mode != MD_REAL && span_c > lim_c) begin
            flt = '{cls: FC_GP, err: idt_err(vector)};
        end
    end
endmodule

// File: rtl/swg_gate_check.sv
module swg_gate_check
    import swg_pkg::*;
#(
    parameter int LIMIT_W = 16
) (
    input  logic [1:0]         mode,
    input  logic [1:0]         cpl,
    input  logic [7:0]         vector,
    input  logic [3:0]         gtype,
    input  logic               gsys,
    input  logic [1:0]         gdpl,
    input  logic               gpres,
    input  logic [13:0]        sel_hi,
    input  logic               ldt_null,
    input  logic [LIMIT_W-1:0] gdt_limit,
    input  logic [LIMIT_W-1:0] ldt_limit,
    output fault_t             flt,
    output logic               is_task
);
    localparam int CW = (LIMIT_W > 16) ? LIMIT_W : 16;

    logic          type_ok;
    logic [CW-1:0] sel_span;
    logic [CW-1:0] tbl_lim;

    always_comb begin
        if (mode == MD_LONG)
            type_ok = !gsys && (gtype == 4'hE || gtype == 4'hF);
        else
            type_ok = !gsys && (gtype == 4'h5 || gtype == 4'h6 || gtype == 4'h7 ||
                                gtype == 4'hE || gtype == 4'hF);
        is_task  = (mode != MD_LONG) && (gtype == 4'h5);
        sel_span = CW'({sel_hi[13:1], 3'b111});
        tbl_lim  = sel_hi[0] ? CW'(ldt_limit) : CW'(gdt_limit);
        flt      = NO_FAULT;
        if (!type_ok)
            flt = '{cls: FC_GP, err: idt_err(vector)};
        else if (gdpl < cpl)
            flt = '{cls: FC_GP, err: idt_err(vector)};
        else if (!gpres)
            flt = '{cls: FC_NP, err: idt_err(vector)};
        else if (!is_task) begin
            if (sel_hi == 14'd0)
                flt = '{cls: FC_GP, err: 16'h0000};
            else if (sel_hi[0] && ldt_null)
                flt = '{cls: FC_GP, err: sel_err(sel_hi)};
            else if (sel_span > tbl_lim)
                flt = '{cls: FC_GP, err: sel_err(sel_hi)};
        end
    end
endmodule

// File: rtl/swg_target_check.sv
module swg_target_check
    import swg_pkg::*;
(
    input  logic [1:0]  mode,
    input  logic [1:0]  cpl,
    input  logic        t_s,
    input  logic        t_code,
    input  logic        t_long,
    input  logic [1:0]  t_dpl,
    input  logic        t_pres,
    input  logic [13:0] sel_hi,
    output fault_t      flt
);
    logic code_ok;

    always_comb begin
        code_ok = t_s && t_code && ((mode != MD_LONG) || t_long);
        flt     = NO_FAULT;
        if (!code_ok)
            flt = '{cls: FC_GP, err: sel_err(sel_hi)};
        else if (t_dpl > cpl)
            flt = '{cls: FC_GP, err: sel_err(sel_hi)};
        else if (!t_pres)
            flt = '{cls: FC_NP, err: sel_err(sel_hi)};
    end
endmodule

// File: rtl/swint_gate_check.sv
module swint_gate_check
    import swg_pkg::*;
#(
    parameter int ADDR_W  = 32,
    parameter int LIMIT_W = 16
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               start,
    input  logic [7:0]         vector,
    input  logic [1:0]         mode,
    input  logic [1:0]         cpl,
    input  logic [1:0]         iopl,
    input  logic               vme_en,
    input  logic               redir_bit,
    input  logic [ADDR_W-1:0]  idt_base,
    input  logic [LIMIT_W-1:0] idt_limit,
    input  logic [ADDR_W-1:0]  gdt_base,
    input  logic [LIMIT_W-1:0] gdt_limit,
    input  logic [ADDR_W-1:0]  ldt_base,
    input  logic [LIMIT_W-1:0] ldt_limit,
    input  logic               ldt_null,
    output logic               mem_req,
    output logic [ADDR_W-1:0]  mem_addr,
    input  logic               mem_rvalid,
    input  logic [63:0]        mem_rdata,
    output logic               done,
    output logic               ok,
    output logic [1:0]         fault_cls,
    output logic [15:0]        err_code,
    output logic [15:0]        hnd_sel,
    output logic [31:0]        hnd_off
);
    typedef struct packed {
        state_e      st;
        logic        ok;
        fclass_e     cls;
        logic [15:0] err;
        logic [15:0] sel;
        logic [31:0] off;
        logic [15:0] gsel;
        logic [31:0] goff;
    } regs_t;

    regs_t r_d, r_q;

    fault_t entry_flt, gate_flt, tgt_flt;
    logic   gate_task;
    logic   rsvd_unused;

    assign rsvd_unused = ^mem_rdata[39:32];

    swg_entry_check #(.LIMIT_W(LIMIT_W)) u_entry (
        .mode(mode), .iopl(iopl), .vme_en(vme_en), .redir_bit(redir_bit),
        .vector(vector), .idt_limit(idt_limit), .flt(entry_flt)
    );

    swg_gate_check #(.LIMIT_W(LIMIT_W)) u_gate (
        .mode(mode), .cpl(cpl), .vector(vector),
        .gtype(mem_rdata[43:40]), .gsys(mem_rdata[44]), .gdpl(mem_rdata[46:45]),
        .gpres(mem_rdata[47]), .sel_hi(mem_rdata[31:18]), .ldt_null(ldt_null),
        .gdt_limit(gdt_limit), .ldt_limit(ldt_limit),
        .flt(gate_flt), .is_task(gate_task)
    );

    swg_target_check u_tgt (
        .mode(mode), .cpl(cpl),
        .t_s(mem_rdata[44]), .t_code(mem_rdata[43]), .t_long(mem_rdata[53]),
        .t_dpl(mem_rdata[46:45]), .t_pres(mem_rdata[47]),
        .sel_hi(r_q.gsel[15:2]), .flt(tgt_flt)
    );

    // memory port
    logic [ADDR_W-1:0] gate_ofs, tgt_ofs;
    always_comb begin
        unique case (mode)
            MD_REAL: gate_ofs = ADDR_W'({vector, 2'b00});
            MD_LONG: gate_ofs = ADDR_W'({vector, 4'b0000});
            default: gate_ofs = ADDR_W'({vector, 3'b000});
        endcase
        tgt_ofs  = ADDR_W'({r_q.gsel[15:3], 3'b000});
        mem_req  = (r_q.st == ST_GATE) || (r_q.st == ST_TGT);
        mem_addr = (r_q.st == ST_TGT) ? ((r_q.gsel[2] ? ldt_base : gdt_base) + tgt_ofs)
                                      : (idt_base + gate_ofs);
    end

    // next state
    always_comb begin
        r_d = r_q;
        unique case (r_q.st)
            ST_IDLE: begin
                if (start) begin
                    if (entry_flt.cls != FC_NONE) begin
                        r_d.st  = ST_DONE;
                        r_d.ok  = 1'b0;
                        r_d.cls = entry_flt.cls;
                        r_d.err = entry_flt.err;
                    end else begin
                        r_d.st = ST_GATE;
                    end
                end
            end
            ST_GATE: begin
                if (mem_rvalid) begin
                    if (mode == MD_REAL) begin
                        r_d.st  = ST_DONE;
                        r_d.ok  = 1'b1;
                        r_d.cls = FC_NONE;
                        r_d.err = 16'h0000;
                        r_d.sel = mem_rdata[31:16];
                        r_d.off = {16'h0000, mem_rdata[15:0]};
                    end else if (gate_flt.cls != FC_NONE) begin
                        r_d.st  = ST_DONE;
                        r_d.ok  = 1'b0;
                        r_d.cls = gate_flt.cls;
                        r_d.err = gate_flt.err;
                    end else if (gate_task) begin
                        r_d.st  = ST_DONE;
                        r_d.ok  = 1'b1;
                        r_d.cls = FC_NONE;
                        r_d.err = 16'h0000;
                        r_d.sel = mem_rdata[31:16];
                        r_d.off = {mem_rdata[63:48], mem_rdata[15:0]};
                    end else begin
                        r_d.st   = ST_TGT;
                        r_d.gsel = mem_rdata[31:16];
                        r_d.goff = {mem_rdata[63:48], mem_rdata[15:0]};
                    end
                end
            end
            ST_TGT: begin
                if (mem_rvalid) begin
                    r_d.st = ST_DONE;
                    if (tgt_flt.cls != FC_NONE) begin
                        r_d.ok  = 1'b0;
                        r_d.cls = tgt_flt.cls;
                        r_d.err = tgt_flt.err;
                    end else begin
                        r_d.ok  = 1'b1;
                        r_d.cls = FC_NONE;
                        r_d.err = 16'h0000;
                        r_d.sel = r_q.gsel;
                        r_d.off = r_q.goff;
                    end
                end
            end
            default: r_d.st = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            r_q <= '{st: ST_IDLE, ok: 1'b0, cls: FC_NONE, err: '0, sel: '0,
                     off: '0, gsel: '0, goff: '0};
        end else begin
            r_q <= r_d;
        end
    end

    assign done      = (r_q.st == ST_DONE);
    assign ok        = r_q.ok;
    assign fault_cls = r_q.cls;
    assign err_code  = r_q.err;
    assign hnd_sel   = r_q.sel;
    assign hnd_off   = r_q.off;

    // checks on the control flow
    assert_done_pulse_R13: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done);

    assert_addr_stable_R13: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_req && !mem_rvalid) |=> (mem_req && $stable(mem_addr)));

    assert_ok_clean_R14: assert property (@(posedge clk) disable iff (!rst_n)
        (done && ok) |-> (fault_cls == 2'd0 && err_code == 16'h0000));

    assert_fault_not_ok_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (done && fault_cls != 2'd0) |-> !ok);

    assert_v86_fault_R1: assert property (@(posedge clk) disable iff (!rst_n)
        (r_q.st == ST_IDLE && start && mode == 2'd1 && iopl != 2'd3 && !vme_en)
        |=> (done && fault_cls == 2'd1 && err_code == 16'h0000 && !mem_req));
endmodule

// File: tb/swint_gate_check_test.sv
module swint_gate_check_test;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        start = 1'b0;
    logic [7:0]  vector = '0;
    logic [1:0]  mode = '0, cpl = '0, iopl = '0;
    logic        vme_en = 1'b0, redir_bit = 1'b0, ldt_null = 1'b0;
    logic [31:0] idt_base = 32'h0000_0000, gdt_base = 32'h0000_0400, ldt_base = 32'h0000_0600;
    logic [15:0] idt_limit = 16'h00FF, gdt_limit = 16'h003F, ldt_limit = 16'h001F;
    logic        mem_req, mem_rvalid = 1'b0;
    logic [31:0] mem_addr;
    logic [63:0] mem_rdata = '0;
    logic        done, ok;
    logic [1:0]  fault_cls;
    logic [15:0] err_code, hnd_sel;
    logic [31:0] hnd_off;

    logic [63:0] mem [256];

    int checks = 0;
    int failures = 0;

    always #5 clk = ~clk;

    swint_gate_check uut (
        .clk(clk), .rst_n(rst_n), .start(start), .vector(vector), .mode(mode),
        .cpl(cpl), .iopl(iopl), .vme_en(vme_en), .redir_bit(redir_bit),
        .idt_base(idt_base), .idt_limit(idt_limit), .gdt_base(gdt_base),
        .gdt_limit(gdt_limit), .ldt_base(ldt_base), .ldt_limit(ldt_limit),
        .ldt_null(ldt_null), .mem_req(mem_req), .mem_addr(mem_addr),
        .mem_rvalid(mem_rvalid), .mem_rdata(mem_rdata), .done(done), .ok(ok),
        .fault_cls(fault_cls), .err_code(err_code), .hnd_sel(hnd_sel), .hnd_off(hnd_off)
    );

    // memory answering one cycle after a request
    always_ff @(posedge clk) begin
        mem_rvalid <= mem_req && !mem_rvalid;
        mem_rdata  <= mem[mem_addr[10:3]] >> (mem_addr[2] ? 32 : 0);
    end

    typedef struct packed {
        logic [1:0]  md;
        logic [1:0]  cpl;
        logic [1:0]  iopl;
        logic        vme;
        logic        rdr;
        logic        ldtn;
        logic [7:0]  vec;
        logic [3:0]  gty;
        logic [1:0]  gdpl;
        logic        gp;
        logic [15:0] gsel;
        logic        tcode;
        logic        tl;
        logic [1:0]  tdpl;
        logic        tp;
        logic [1:0]  ecls;
        logic [15:0] eerr;
        logic [3:0]  elat;
        logic [3:0]  req;
    } vec_t;

    localparam int NV = 28;
    // md cpl iopl vme rdr ldtn vec gty gdpl gp gsel tcode tl tdpl tp ecls eerr elat req
    localparam vec_t TBL [NV] = '{
        '{2'd2,2'd3,2'd0,1'b0,1'b0,1'b0,8'h03,4'hE,2'd3,1'b1,16'h0008,1'b1,1'b0,2'd0,1'b1,2'd0,16'h0000,4'd5,4'd14}, // R14 legacy ok
        '{2'd2,2'd3,2'd0,1'b0,1'b0,1'b0,8'h20,4'hE,2'd3,1'b1,16'h0008,1'b1,1'b0,2'd0,1'b1,2'd1,16'h0102,4'd1,4'd2},  // R2 legacy limit
        '{2'd3,2'd0,2'd0,1'b0,1'b0,1'b0,8'h10,4'hE,2'd0,1'b1,16'h0008,1'b1,1'b1,2'd0,1'b1,2'd1,16'h0082,4'd1,4'd2},  // R2 long 16-byte limit
        '{2'd2,2'd0,2'd0,1'b0,1'b0,1'b0,8'h03,4'hC,2'd0,1'b1,16'h0008,1'b1,1'b0,2'd0,1'b1,2'd1,16'h001A,4'd3,4'd3},  // R3 bad legacy type
        '{2'd3,2'd0,2'd0,1'b0,1'b0,1'b0,8'h03,4'h6,2'd0,1'b1,16'h0008,1'b1,1'b1,2'd0,1'b1,2'd1,16'h001A,4'd3,4'd3},  // R3 16-bit gate in long
        '{2'd3,2'd0,2'd0,1'b0,1'b0,1'b0,8'h03,4'h5,2'd0,1'b1,16'h0008,1'b1,1'b1,2'd0,1'b1,2'd1,16'h001A,4'd3,4'd3},  // R3 task gate in long
        '{2'd2,2'd3,2'd0,1'b0,1'b0,1'b0,8'h03,4'hE,2'd0,1'b1,16'h0008,1'b1,1'b0,2'd0,1'b1,2'd1,16'h001A,4'd3,4'd4},  // R4 gate dpl
        '{2'd2,2'd0,2'd0,1'b0,1'b0,1'b0,8'h03,4'hE,2'd0,1'b0,16'h0008,1'b1,1'b0,2'd0,1'b1,2'd2,16'h001A,4'd3,4'd5},  // R5 gate absent
        '{2'd2,2'd3,2'd0,1'b0,1'b0,1'b0,8'h03,4'hE,2'd0,1'b0,16'h0008,1'b1,1'b0,2'd0,1'b1,2'd1,16'h001A,4'd3,4'd10}, // R10 dpl before presence
        '{2'd2,2'd0,2'd0,1'b0,1'b0,1'b0,8'h03,4'hE,2'd0,1'b1,16'h0000,1'b1,1'b0,2'd0,1'b1,2'd1,16'h0000,4'd3,4'd6},  // R6 null selector
        '{2'd2,2'd0,2'd0,1'b0,1'b0,1'b1,8'h03,4'hE,2'd0,1'b1,16'h000C,1'b1,1'b0,2'd0,1'b1,2'd1,16'h000C,4'd3,4'd6},  // R6 local table null
        '{2'd2,2'd0,2'd0,1'b0,1'b0,1'b0,8'h03,4'hE,2'd0,1'b1,16'h0040,1'b1,1'b0,2'd0,1'b1,2'd1,16'h0040,4'd3,4'd6},  // R6 past global limit
        '{2'd2,2'd0,2'd0,1'b0,1'b0,1'b0,8'h03,4'hE,2'd0,1'b1,16'h004B,1'b1,1'b0,2'd0,1'b1,2'd1,16'h0048,4'd3,4'd6},  // R6 rpl dropped
        '{2'd2,2'd0,2'd0,1'b0,1'b0,1'b0,8'h03,4'hE,2'd0,1'b1,16'h0008,1'b0,1'b0,2'd0,1'b1,2'd1,16'h0008,4'd5,4'd7},  // R7 data target
        '{2'd3,2'd0,2'd0,1'b0,1'b0,1'b0,8'h03,4'hE,2'd0,1'b1,16'h0008,1'b1,1'b0,2'd0,1'b1,2'd1,16'h0008,4'd5,4'd7},  // R7 no 64-bit flag
        '{2'd2,2'd0,2'd0,1'b0,1'b0,1'b0,8'h03,4'hE,2'd0,1'b1,16'h0008,1'b1,1'b0,2'd3,1'b1,2'd1,16'h0008,4'd5,4'd8},  // R8 target dpl
        '{2'd2,2'd0,2'd0,1'b0,1'b0,1'b0,8'h03,4'hE,2'd0,1'b1,16'h0008,1'b1,1'b0,2'd0,1'b0,2'd2,16'h0008,4'd5,4'd9},  // R9 target absent
        '{2'd2,2'd0,2'd0,1'b0,1'b0,1'b0,8'h03,4'hE,2'd0,1'b1,16'h0008,1'b1,1'b0,2'd3,1'b0,2'd1,16'h0008,4'd5,4'd10}, // R10 dpl before presence
        '{2'd3,2'd0,2'd0,1'b0,1'b0,1'b0,8'h03,4'hF,2'd0,1'b1,16'h0008,1'b1,1'b1,2'd0,1'b1,2'd0,16'h0000,4'd5,4'd14}, // R14 long ok
        '{2'd2,2'd1,2'd0,1'b0,1'b0,1'b0,8'h03,4'h7,2'd1,1'b1,16'h000C,1'b1,1'b0,2'd1,1'b1,2'd0,16'h0000,4'd5,4'd14}, // R14 local table ok
        '{2'd2,2'd0,2'd0,1'b0,1'b0,1'b1,8'h03,4'h5,2'd0,1'b1,16'h0028,1'b0,1'b0,2'd3,1'b0,2'd0,16'h0000,4'd3,4'd11}, // R11 task gate
        '{2'd1,2'd3,2'd0,1'b0,1'b0,1'b0,8'h03,4'hE,2'd3,1'b1,16'h0008,1'b1,1'b0,2'd0,1'b1,2'd1,16'h0000,4'd1,4'd1},  // R1 no extensions
        '{2'd1,2'd3,2'd0,1'b1,1'b1,1'b0,8'h03,4'hE,2'd3,1'b1,16'h0008,1'b1,1'b0,2'd0,1'b1,2'd1,16'h0000,4'd1,4'd1},  // R1 bitmap set
        '{2'd1,2'd3,2'd0,1'b1,1'b0,1'b0,8'h03,4'hE,2'd3,1'b1,16'h0008,1'b1,1'b0,2'd0,1'b1,2'd0,16'h0000,4'd5,4'd1},  // R1 bitmap clear
        '{2'd1,2'd3,2'd3,1'b0,1'b1,1'b0,8'h03,4'hE,2'd3,1'b1,16'h0008,1'b1,1'b0,2'd0,1'b1,2'd0,16'h0000,4'd5,4'd1},  // R1 iopl 3
        '{2'd0,2'd0,2'd0,1'b0,1'b0,1'b0,8'h03,4'h0,2'd0,1'b0,16'h0000,1'b0,1'b0,2'd0,1'b0,2'd0,16'h0000,4'd3,4'd12}, // R12 real
        '{2'd0,2'd0,2'd0,1'b0,1'b0,1'b0,8'h80,4'h0,2'd0,1'b0,16'h0000,1'b0,1'b0,2'd0,1'b0,2'd0,16'h0000,4'd3,4'd12}, // R12 real past limit
        '{2'd1,2'd3,2'd0,1'b0,1'b0,1'b0,8'h20,4'hE,2'd3,1'b1,16'h0008,1'b1,1'b0,2'd0,1'b1,2'd1,16'h0000,4'd1,4'd10}  // R10 v86 before limit
    };

    task automatic chk(input logic cond, input int req, input string what,
                       input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (!cond) begin
            failures++;
            $display("FAIL R%0d %s: actual=%h expected=%h", req, what, act, exp);
        end
    endtask

    task automatic load(input vec_t v);
        logic [31:0] ga;
        logic [31:0] ta;
        logic [63:0] tgt;
        mode = v.md; cpl = v.cpl; iopl = v.iopl; vme_en = v.vme;
        redir_bit = v.rdr; ldt_null = v.ldtn; vector = v.vec;
        if (v.md == 2'd0) begin
            ga = {22'd0, v.vec, 2'b00};
            if (ga[2]) mem[ga[10:3]][63:32] = 32'h1234_5678;
            else       mem[ga[10:3]][31:0]  = 32'h1234_5678;
        end else begin
            ga = (v.md == 2'd3) ? {20'd0, v.vec, 4'b0} : {21'd0, v.vec, 3'b0};
            mem[ga[10:3]] = {16'h1234, v.gp, v.gdpl, 1'b0, v.gty, 8'h00, v.gsel, 16'h5678};
            ta  = (v.gsel[2] ? ldt_base : gdt_base) + {16'd0, v.gsel[15:3], 3'b000};
            tgt = '0;
            tgt[53] = v.tl; tgt[47] = v.tp; tgt[46:45] = v.tdpl;
            tgt[44] = 1'b1; tgt[43] = v.tcode; tgt[41] = 1'b1;
            if (ta < 32'h800) mem[ta[10:3]] = tgt;
        end
    endtask

    task automatic run(input vec_t v, output int lat);
        load(v);
        start = 1'b1;
        @(negedge clk);
        start = 1'b0;
        lat = 1;
        while (!done && lat < 15) begin
            @(negedge clk);
            lat++;
        end
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        failures++;
        $display("FAIL watchdog: actual=hung expected=finished");
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    initial begin
        for (int i = 0; i < 256; i++) mem[i] = '0;
        repeat (3) @(negedge clk);
        // reset state (R13)
        chk(done == 1'b0 && mem_req == 1'b0, 13, "reset idle", {30'd0, done, mem_req}, 32'd0);
        chk(ok == 1'b0 && fault_cls == 2'd0, 13, "reset result", {29'd0, ok, fault_cls}, 32'd0);
        rst_n = 1'b1;
        @(negedge clk);

        for (int i = 0; i < NV; i++) begin
            vec_t v;
            int   lat;
            logic [15:0] xs;
            logic [31:0] xo;
            v = TBL[i];
            run(v, lat);
            // latency set by which rule decides (R13)
            chk(lat == int'(v.elat), 13, $sformatf("row %0d latency", i), lat, {28'd0, v.elat});
            chk(done && ok == (v.ecls == 2'd0) && fault_cls == v.ecls, v.req,
                $sformatf("row %0d class", i), {29'd0, ok, fault_cls}, {29'd0, v.ecls == 2'd0, v.ecls});
            chk(err_code == v.eerr, v.req, $sformatf("row %0d error", i), {16'd0, err_code}, {16'd0, v.eerr});
            if (v.ecls == 2'd0) begin
                xs = (v.md == 2'd0) ? 16'h1234 : v.gsel;
                xo = (v.md == 2'd0) ? 32'h0000_5678 : 32'h1234_5678;
                chk(hnd_sel == xs && hnd_off == xo, v.req, $sformatf("row %0d handler", i),
                    {hnd_sel, hnd_off[15:0]}, {xs, xo[15:0]});
                chk(hnd_off == xo, 14, $sformatf("row %0d offset", i), hnd_off, xo);
            end
            @(negedge clk);
        end

        // results held after the done pulse (R13)
        begin
            int lat;
            run(TBL[16], lat);
            repeat (3) @(negedge clk);
            chk(!done, 13, "done pulse ended", {31'd0, done}, 32'd0);
            chk(fault_cls == 2'd2 && err_code == 16'h0008, 13, "result held",
                {14'd0, fault_cls, err_code}, {14'd0, 2'd2, 16'h0008});
            chk(!mem_req, 13, "no request when idle", {31'd0, mem_req}, 32'd0);
        end

        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end
endmodule